// File: doc/BRIEF.md
# Relative Branch Program Counter Unit

This block works out the address of the next instruction for a core with 16-bit instruction words and a 21-bit byte-addressed program counter. It recognises three kinds of instruction whose target is counted relative to the following instruction: the eight flag-tested branches, the unconditional branch with a long offset, and the relative subroutine call. For every accepted instruction it registers the next PC, a flag saying whether the flow was redirected, and the return address. For a relative call it also raises a push request so that a separate return stack can store that return address.

The core presents the instruction word together with its own PC and the four arithmetic flags (carry, zero, overflow, negative), and pulses a valid strobe. One clock edge later the results appear on the outputs. They then hold until the next accepted instruction. Any instruction that is not one of the three relative kinds simply steps the PC to the next word.

Top module: `rbpc_top`

## Requirements
- R1: An instruction whose bits 15:11 are 11100 is a flag-tested branch. Bits 10:9 pick the flag (00 zero, 01 carry, 10 overflow, 11 negative). Bit 8 picks the polarity: 0 branches when the flag is 1, and 1 branches when the flag is 0. `branchTaken` reports the outcome.
- R2: For a flag-tested branch that is taken, bits 7:0 are a signed word offset n, and `nextPc` becomes PC+2+2*n.
- R3: For a flag-tested branch that is not taken, `nextPc` becomes PC+2 and `branchTaken` is 0.
- R4: An instruction whose bits 15:11 are 11010 always branches. Bits 10:0 are a signed word offset n, and `nextPc` becomes PC+2+2*n with `branchTaken` at 1 and `pushReq` at 0.
- R5: An instruction whose bits 15:11 are 11011 is a relative call. It sets `pushReq` and `branchTaken` to 1, and `nextPc` becomes PC+2+2*n with n taken from the signed bits 10:0.
- R6: Bit 0 of the incoming PC is ignored, and bit 0 of `nextPc` and of `pushAddr` is always 0.
- R7: Every accepted instruction loads `pushAddr` with PC+2. All address sums wrap modulo 2^21.
- R8: Any other instruction, including upper bytes 0xE8 to 0xEF, gives `nextPc` = PC+2 with `branchTaken` and `pushReq` both 0.
- R9: While `instrValid` is low, `nextPc`, `branchTaken`, `pushReq` and `pushAddr` hold their values whatever the other inputs do.
- R10: While `rstN` is low, `nextPc` and `pushAddr` are 0, and `branchTaken` and `pushReq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | Instruction word and PC are to be accepted this cycle |
| instrWord | input | 16 | Instruction word |
| curPc | input | 21 | Byte address of the current instruction |
| flagCarry | input | 1 | Carry flag |
| flagZero | input | 1 | Zero flag |
| flagOverflow | input | 1 | Overflow flag |
| flagNegative | input | 1 | Negative flag |
| nextPc | output | 21 | Registered address of the next instruction |
| branchTaken | output | 1 | Registered: the accepted instruction redirected the flow |
| pushReq | output | 1 | Registered: the return stack should store `pushAddr` |
| pushAddr | output | 21 | Registered return address, PC+2 |

## Verification
Each result is due exactly one rising edge after the edge at which `instrValid` is sampled high. The datapath has a single register stage, so nothing is due later. The bench changes inputs on the falling edge, leaves `instrValid` high for exactly one rising edge, and reads the outputs on the next falling edge. For the hold and reset checks it waits several further falling edges, so that any stray update would have had time to show.

// File: rtl/rbpc_pkg.sv
package rbpc_pkg;

  // Strobes from the decode/control half to the address datapath
  typedef struct packed {
    logic take;     // redirect to the relative target
    logic longOff;  // use the wide offset field instead of the short one
    logic push;     // request a return-stack push
  } rbpcStrobe_t;

  typedef enum logic [1:0] {
    FLAG_ZERO = 2'd0,
    FLAG_CARRY = 2'd1,
    FLAG_OVFL = 2'd2,
    FLAG_NEG = 2'd3
  } flagSel_e;

  localparam logic [4:0] GRP_COND = 5'b11100;
  localparam logic [4:0] GRP_BRA = 5'b11010;
  localparam logic [4:0] GRP_CALL = 5'b11011;

endpackage

// File: rtl/rbpc_ctrl.sv
module rbpc_ctrl
  import rbpc_pkg::*;
#(
  parameter int INSTR_W = 16
) (
  input  logic [INSTR_W-1:0] instrWord,
  input  logic               flagCarry,
  input  logic               flagZero,
  input  logic               flagOverflow,
  input  logic               flagNegative,
  output rbpcStrobe_t        strobe
);

  localparam int GRP_HI = INSTR_W - 1;
  localparam int GRP_LO = INSTR_W - 5;

  logic [4:0] grpField;
  logic       isCond;
  logic       isBra;
  logic       isCall;
  flagSel_e   flagSel;
  logic       invertSense;
  logic       flagVal;
  logic       condHit;

  assign grpField = instrWord[GRP_HI:GRP_LO];
  assign isCond = (grpField == GRP_COND);
  assign isBra = (grpField == GRP_BRA);
  assign isCall = (grpField == GRP_CALL);

  assign flagSel = flagSel_e'(instrWord[GRP_LO-1:GRP_LO-2]);
  assign invertSense = instrWord[GRP_LO-3];

  always_comb begin
    unique case (flagSel)
      FLAG_ZERO: flagVal = flagZero;
      FLAG_CARRY: flagVal = flagCarry;
      FLAG_OVFL: flagVal = flagOverflow;
      FLAG_NEG: flagVal = flagNegative;
      default: flagVal = 1'b0;
    endcase
  end

  assign condHit = flagVal ^ invertSense;

  always_comb begin
    strobe.take = (isCond & condHit) | isBra | isCall;
    strobe.longOff = isBra | isCall;
    strobe.push = isCall;
  end

endmodule

// File: rtl/rbpc_datapath.sv
module rbpc_datapath
  import rbpc_pkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int PC_W = 21,
  parameter int SHORT_W = 8,
  parameter int LONG_W = 11,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [PC_W-1:0]    curPc,
  input  rbpcStrobe_t        strobe,
  output logic [PC_W-1:0]    nextPc,
  output logic               branchTaken,
  output logic               pushReq,
  output logic [PC_W-1:0]    pushAddr
);

  localparam int SHORT_PAD = PC_W - SHORT_W;
  localparam int LONG_PAD = PC_W - LONG_W;
  localparam logic [PC_W-1:0] STEP = PC_W'(2);

  logic [PC_W-1:0] pcBase;
  logic [PC_W-1:0] pcSeq;
  logic [PC_W-1:0] shortExt;
  logic [PC_W-1:0] longExt;
  logic [PC_W-1:0] offWords;
  logic [PC_W-1:0] offBytes;
  logic [PC_W-1:0] target;
  logic [PC_W-1:0] pcNxtD;

  assign pcBase = {curPc[PC_W-1:1], 1'b0};
  assign pcSeq = pcBase + STEP;

  assign shortExt = {{SHORT_PAD{instrWord[SHORT_W-1]}}, instrWord[SHORT_W-1:0]};
  assign longExt = {{LONG_PAD{instrWord[LONG_W-1]}}, instrWord[LONG_W-1:0]};
  assign offWords = strobe.longOff ? longExt : shortExt;
  assign offBytes = {offWords[PC_W-2:0], 1'b0};
  assign target = pcSeq + offBytes;
  assign pcNxtD = strobe.take ? target : pcSeq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextPc <= RESET_PC;
      branchTaken <= 1'b0;
      pushReq <= 1'b0;
      pushAddr <= '0;
    end else if (instrValid) begin
      nextPc <= pcNxtD;
      branchTaken <= strobe.take;
      pushReq <= strobe.push;
      pushAddr <= pcSeq;
    end
  end

endmodule

// File: rtl/rbpc_top.sv
module rbpc_top
  import rbpc_pkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int PC_W = 21,
  parameter int SHORT_W = 8,
  parameter int LONG_W = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [PC_W-1:0]    curPc,
  input  logic               flagCarry,
  input  logic               flagZero,
  input  logic               flagOverflow,
  input  logic               flagNegative,
  output logic [PC_W-1:0]    nextPc,
  output logic               branchTaken,
  output logic               pushReq,
  output logic [PC_W-1:0]    pushAddr
);

  rbpcStrobe_t strobe;

  rbpc_ctrl #(
    .INSTR_W(INSTR_W)
  ) u_ctrl (
    .instrWord   (instrWord),
    .flagCarry   (flagCarry),
    .flagZero    (flagZero),
    .flagOverflow(flagOverflow),
    .flagNegative(flagNegative),
    .strobe      (strobe)
  );

  rbpc_datapath #(
    .INSTR_W (INSTR_W),
    .PC_W    (PC_W),
    .SHORT_W (SHORT_W),
    .LONG_W  (LONG_W),
    .RESET_PC('0)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .instrValid (instrValid),
    .instrWord  (instrWord),
    .curPc      (curPc),
    .strobe     (strobe),
    .nextPc     (nextPc),
    .branchTaken(branchTaken),
    .pushReq    (pushReq),
    .pushAddr   (pushAddr)
  );

endmodule

// File: rtl/rbpc_checker.sv
module rbpc_checker #(
  parameter int INSTR_W = 16,
  parameter int PC_W = 21
) (
  input logic               clk,
  input logic               rstN,
  input logic               instrValid,
  input logic [INSTR_W-1:0] instrWord,
  input logic [PC_W-1:0]    curPc,
  input logic [PC_W-1:0]    nextPc,
  input logic               branchTaken,
  input logic               pushReq,
  input logic [PC_W-1:0]    pushAddr
);

  logic [4:0] grp;
  logic       isRel;
  assign grp = instrWord[INSTR_W-1:INSTR_W-5];
  assign isRel = (grp == 5'b11100) || (grp == 5'b11010) || (grp == 5'b11011);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !instrValid |=> ($stable(nextPc) && $stable(branchTaken)
                     && $stable(pushReq) && $stable(pushAddr)));

  p_even_r6: assert property (@(posedge clk) disable iff (!rstN)
    (nextPc[0] == 1'b0) && (pushAddr[0] == 1'b0));

  p_seq_when_not_taken_r3: assert property (@(posedge clk) disable iff (!rstN)
    instrValid |=> (!branchTaken -> (nextPc == pushAddr)));

  p_call_pushes_r5: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && grp == 5'b11011) |=> (pushReq && branchTaken));

  p_bra_taken_r4: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && grp == 5'b11010) |=> (branchTaken && !pushReq));

  p_other_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && !isRel) |=> (!branchTaken && !pushReq));

  p_ret_addr_r7: assert property (@(posedge clk) disable iff (!rstN)
    instrValid |=> (pushAddr == ({$past(curPc[PC_W-1:1]), 1'b0} + PC_W'(2))));

endmodule

bind rbpc_top rbpc_checker #(
  .INSTR_W(INSTR_W),
  .PC_W   (PC_W)
) u_rbpc_checker (
  .clk        (clk),
  .rstN       (rstN),
  .instrValid (instrValid),
  .instrWord  (instrWord),
  .curPc      (curPc),
  .nextPc     (nextPc),
  .branchTaken(branchTaken),
  .pushReq    (pushReq),
  .pushAddr   (pushAddr)
);

// File: tb/test_rbpc_top.sv
module test_rbpc_top;

  localparam int PC_W = 21;
  localparam int NVEC = 21;

  typedef struct packed {
    logic [3:0]      req;
    logic [15:0]     instr;
    logic [PC_W-1:0] pc;
    logic [3:0]      flags;   // {negative, overflow, zero, carry}
    logic [PC_W-1:0] expPc;
    logic            expTaken;
    logic            expPush;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{4'd1,  16'hE005, 21'h001000, 4'b0010, 21'h00100C, 1'b1, 1'b0}, // R1 zero set
    '{4'd3,  16'hE005, 21'h001000, 4'b0000, 21'h001002, 1'b0, 1'b0}, // R3 zero clear
    '{4'd2,  16'hE1FE, 21'h002000, 4'b0000, 21'h001FFE, 1'b1, 1'b0}, // R2 negative offset
    '{4'd1,  16'hE203, 21'h000100, 4'b0001, 21'h000108, 1'b1, 1'b0}, // R1 carry set
    '{4'd3,  16'hE303, 21'h000100, 4'b0001, 21'h000102, 1'b0, 1'b0}, // R3 not-carry fails
    '{4'd1,  16'hE410, 21'h000400, 4'b0100, 21'h000422, 1'b1, 1'b0}, // R1 overflow set
    '{4'd1,  16'hE510, 21'h000400, 4'b0000, 21'h000422, 1'b1, 1'b0}, // R1 no overflow
    '{4'd2,  16'hE680, 21'h001000, 4'b1000, 21'h000F02, 1'b1, 1'b0}, // R2 offset -128
    '{4'd2,  16'hE77F, 21'h001000, 4'b0000, 21'h001100, 1'b1, 1'b0}, // R2 offset +127
    '{4'd3,  16'hE77F, 21'h001000, 4'b1000, 21'h001002, 1'b0, 1'b0}, // R3 negative set
    '{4'd4,  16'hD3FF, 21'h010000, 4'b0000, 21'h010800, 1'b1, 1'b0}, // R4 offset +1023
    '{4'd4,  16'hD400, 21'h010000, 4'b1111, 21'h00F802, 1'b1, 1'b0}, // R4 offset -1024
    '{4'd5,  16'hD802, 21'h003000, 4'b0000, 21'h003006, 1'b1, 1'b1}, // R5 call forward
    '{4'd5,  16'hDFFF, 21'h003000, 4'b0000, 21'h003000, 1'b1, 1'b1}, // R5 call -1
    '{4'd7,  16'hD3FF, 21'h1FFFFE, 4'b0000, 21'h0007FE, 1'b1, 1'b0}, // R7 wrap up
    '{4'd7,  16'hE0FE, 21'h000000, 4'b0010, 21'h1FFFFE, 1'b1, 1'b0}, // R7 wrap down
    '{4'd6,  16'hE001, 21'h001001, 4'b0010, 21'h001004, 1'b1, 1'b0}, // R6 odd pc
    '{4'd8,  16'h0000, 21'h000500, 4'b1111, 21'h000502, 1'b0, 1'b0}, // R8 nop
    '{4'd8,  16'hE805, 21'h000500, 4'b1111, 21'h000502, 1'b0, 1'b0}, // R8 upper byte E8
    '{4'd8,  16'hEF12, 21'h000500, 4'b1111, 21'h000502, 1'b0, 1'b0}, // R8 upper byte EF
    '{4'd8,  16'hC805, 21'h000500, 4'b1111, 21'h000502, 1'b0, 1'b0}  // R8 group 11001
  };

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            instrValid = 1'b0;
  logic [15:0]     instrWord = '0;
  logic [PC_W-1:0] curPc = '0;
  logic            flagCarry = 1'b0;
  logic            flagZero = 1'b0;
  logic            flagOverflow = 1'b0;
  logic            flagNegative = 1'b0;
  logic [PC_W-1:0] nextPc;
  logic            branchTaken;
  logic            pushReq;
  logic [PC_W-1:0] pushAddr;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  rbpc_top i_rbpc_top (
    .clk         (clk),
    .rstN        (rstN),
    .instrValid  (instrValid),
    .instrWord   (instrWord),
    .curPc       (curPc),
    .flagCarry   (flagCarry),
    .flagZero    (flagZero),
    .flagOverflow(flagOverflow),
    .flagNegative(flagNegative),
    .nextPc      (nextPc),
    .branchTaken (branchTaken),
    .pushReq     (pushReq),
    .pushAddr    (pushAddr)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [15:0] iw, input logic [PC_W-1:0] pc,
                       input logic [3:0] fl);
    @(negedge clk);
    instrWord = iw;
    curPc = pc;
    {flagNegative, flagOverflow, flagZero, flagCarry} = fl;
    instrValid = 1'b1;
    @(negedge clk);
    instrValid = 1'b0;
  endtask

  function automatic logic [PC_W-1:0] retOf(input logic [PC_W-1:0] pc);
    return {pc[PC_W-1:1], 1'b0} + PC_W'(2);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    string tag;
    repeat (3) @(negedge clk);
    // R10: reset values while reset is held
    check("R10", "nextPc", 32'(nextPc), 32'h0);
    check("R10", "branchTaken", 32'(branchTaken), 32'h0);
    check("R10", "pushReq", 32'(pushReq), 32'h0);
    check("R10", "pushAddr", 32'(pushAddr), 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      issue(VECS[i].instr, VECS[i].pc, VECS[i].flags);
      tag = $sformatf("R%0d", VECS[i].req);
      check(tag, $sformatf("vec%0d nextPc", i), 32'(nextPc), 32'(VECS[i].expPc));
      check(tag, $sformatf("vec%0d taken", i), 32'(branchTaken), 32'(VECS[i].expTaken));
      check(tag, $sformatf("vec%0d push", i), 32'(pushReq), 32'(VECS[i].expPush));
      // R7: return address follows every accepted instruction
      check("R7", $sformatf("vec%0d pushAddr", i), 32'(pushAddr), 32'(retOf(VECS[i].pc)));
    end

    // R9: inputs change with valid low; outputs must not move
    issue(16'hE005, 21'h004000, 4'b0010);   // taken, nextPc 0x00400C
    @(negedge clk);
    instrWord = 16'hD802;
    curPc = 21'h007000;
    {flagNegative, flagOverflow, flagZero, flagCarry} = 4'b1111;
    repeat (3) @(negedge clk);
    check("R9", "nextPc held", 32'(nextPc), 32'h00400C);
    check("R9", "taken held", 32'(branchTaken), 32'h1);
    check("R9", "push held", 32'(pushReq), 32'h0);
    check("R9", "pushAddr held", 32'(pushAddr), 32'h004002);

    // R9: a call result also holds while idle
    issue(16'hD802, 21'h005000, 4'b0000);
    instrWord = 16'h0000;
    repeat (3) @(negedge clk);
    check("R9", "push stays", 32'(pushReq), 32'h1);
    check("R9", "call target held", 32'(nextPc), 32'h005006);

    // R10: reset in mid-run clears a pending push
    rstN = 1'b0;
    @(negedge clk);
    check("R10", "push cleared", 32'(pushReq), 32'h0);
    check("R10", "nextPc cleared", 32'(nextPc), 32'h0);
    check("R10", "taken cleared", 32'(branchTaken), 32'h0);
    check("R10", "pushAddr cleared", 32'(pushAddr), 32'h0);
    rstN = 1'b1;

    // R1: inverted zero test after reset
    issue(16'hE1FE, 21'h000010, 4'b0010);
    check("R1", "zero set, inverted", 32'(branchTaken), 32'h0);
    check("R1", "zero set, inverted pc", 32'(nextPc), 32'h000012);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule